// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. It watches the clock and data lines, which it samples on its own system clock, and finds the bus conditions that open and close transfers. It shifts bytes in and out on those lines. When it acknowledges a byte, it pulls the data line low through an open-drain enable. The storage is a 256-byte array, modelled as registers, with every byte reading 8'hFF after reset.

A write names the device, gives a one-byte word address, and then sends any number of data bytes. These bytes are collected in a 16-slot page buffer. A Stop commits them in one simulated programming cycle whose length, in system clocks, comes from an input. During that cycle the slave acknowledges nothing. A read names the device with the direction bit set. It returns bytes from the current word address for as long as the master keeps acknowledging them.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high) opens a new transaction at bit zero, even when it arrives in the middle of a byte. A Stop (SDA rising while SCL is high) closes the transaction and releases SDA.
- R2: A device byte is acknowledged when its upper seven bits equal 7'b1010000, with the lowest bit as R/W (0 = write, 1 = read). The slave acknowledges by driving SDA low for the whole high time of the ninth SCL pulse. Any other device byte gets no acknowledge, and later bytes are then ignored until the next Start, leaving the word address unchanged.
- R3: `sda_oe` changes only while the synchronised SCL is low, or when a Start or Stop occurs. Read data therefore stays stable while SCL is high.
- R4: In a write, the byte after the device byte is the word address. Each later data byte is acknowledged.
- R5: A Stop that ends a write carrying at least one data byte starts a programming cycle of `prog_cycles` system clocks. The buffered bytes reach the array when that cycle ends.
- R6: While a programming cycle runs, the slave acknowledges no byte, including a matching device byte.
- R7: Buffered write bytes step through the low four address bits and wrap inside one 16-byte page. When more than 16 bytes are written, a later byte overwrites the oldest one in its slot. Bytes outside the page are left unchanged.
- R8: A read shifts each byte out MSB first, one bit per SCL pulse. The word address increments after each byte and wraps from 8'hFF to 8'h00.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and stays released until the next Start.
- R10: A write that stops after the word address starts no programming cycle. A read that follows, with or without a repeated Start, begins at that address.
- R11: After reset, SDA is released and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| prog_cycles | input | 16 | Length of the programming cycle in system clocks |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
SCL and SDA pass through two synchroniser stages and one edge register. As a result, `sda_oe` moves about three system clocks after an SCL falling edge, and a Start or Stop takes effect at the same delay. The bench therefore changes SDA only a quarter bit (8 clocks) after SCL falls. It reads acknowledges and data a quarter bit after SCL rises, and reads data a second time just before SCL falls. The programming cycle starts a few clocks after the Stop and runs for `prog_cycles` clocks. For this reason the busy probe is sent right after the Stop, and finishes its device byte well inside a 400-clock window. Read-back waits `prog_cycles` plus a 40-clock margin.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned PW    = 4;
  localparam int unsigned SLOTS = 1 << PW;
  localparam int unsigned DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // next buffered write address: only the in-page bits advance
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    r[PW-1:0] = a[PW-1:0] + 1'b1;
    return r;
  endfunction

  // next read address: full-width wrap
  function automatic logic [AW-1:0] seq_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic dev_hit(input logic [DW-1:0] b, input logic [6:0] id);
    return b[DW-1:1] == id;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  logic [PW-1:0]       push_slot,
  input  logic [DW-1:0]       push_data,
  input  logic                base_set,
  input  logic [AW-PW-1:0]    base_page,
  input  logic                commit_req,
  input  logic [CW-1:0]       prog_cycles,
  output logic                busy,
  output logic                any_valid,
  output logic                wr_fire,
  output logic [AW-PW-1:0]    wr_page,
  output logic [SLOTS*DW-1:0] wr_data,
  output logic [SLOTS-1:0]    wr_mask
);
  logic [DW-1:0]    slot [SLOTS];
  logic [SLOTS-1:0] vld;
  logic [CW-1:0]    tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld     <= '0;
      wr_page <= '0;
      tmr     <= '0;
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else begin
      if (wr_fire || (clear && !busy)) vld <= '0;
      else if (push) begin
        vld[push_slot]  <= 1'b1;
        slot[push_slot] <= push_data;
      end
      if (base_set) wr_page <= base_page;
      if (commit_req && !busy) tmr <= (prog_cycles == '0) ? CW'(1) : prog_cycles;
      else if (tmr != '0)      tmr <= tmr - 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_flat
      assign wr_data[g*DW +: DW] = slot[g];
    end
  endgenerate

  assign wr_mask   = vld;
  assign busy      = (tmr != '0);
  assign any_valid = |vld;
  assign wr_fire   = (tmr == CW'(1));

  assert_busy_from_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_req))
    else $error("busy rose without a commit request");
  assert_fire_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> any_valid)
    else $error("array write fired with an empty buffer");
endmodule

// File: rtl/eep_array.sv
module eep_array
  import eep_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [AW-PW-1:0]    wr_page,
  input  logic [SLOTS*DW-1:0] wr_data,
  input  logic [SLOTS-1:0]    wr_mask,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_fire) begin
      for (int s = 0; s < SLOTS; s++)
        if (wr_mask[s]) mem[{wr_page, s[PW-1:0]}] <= wr_data[s*DW +: DW];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ID = 7'b1010000,
  parameter int unsigned CW     = 16,
  parameter int unsigned SYNC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [CW-1:0] prog_cycles,
  output logic          sda_oe
);
  localparam int unsigned PGW = AW - PW;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  phase_t phase, nxt_phase;
  logic [3:0] bit_cnt;
  logic [DW-1:0] shreg, tx, byte_in, rd_data;
  logic [AW-1:0] addr;
  logic oe_q, ack_pend, rd_go;
  logic busy, any_valid, wr_fire, commit_req;
  logic rx_phase, byte_done, ack_go, push, base_set, end_fall, mack_rise;
  logic [PGW-1:0] wr_page;
  logic [SLOTS*DW-1:0] wr_data;
  logic [SLOTS-1:0] wr_mask;

  i2c_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // named bus events
  assign byte_in    = {shreg[DW-2:0], sda_lvl};
  assign rx_phase   = (phase == PH_DEV) || (phase == PH_WADR) || (phase == PH_WDAT);
  assign byte_done  = scl_rise && rx_phase && (bit_cnt == 4'd7);
  assign end_fall   = scl_fall && (phase != PH_IDLE) && (bit_cnt == 4'd9);
  assign mack_rise  = scl_rise && (phase == PH_RDAT) && (bit_cnt == 4'd8) && !ack_pend;
  assign commit_req = stop_det && (phase == PH_WDAT) && any_valid;

  always_comb begin
    ack_go    = 1'b0;
    push      = 1'b0;
    base_set  = 1'b0;
    nxt_phase = phase;
    if (byte_done) begin
      case (phase)
        PH_DEV: begin
          if (dev_hit(byte_in, DEV_ID) && !busy) begin
            ack_go    = 1'b1;
            nxt_phase = byte_in[0] ? PH_RDAT : PH_WADR;
          end else begin
            nxt_phase = PH_IDLE;
          end
        end
        PH_WADR: begin
          ack_go    = 1'b1;
          base_set  = 1'b1;
          nxt_phase = PH_WDAT;
        end
        PH_WDAT: begin
          ack_go = 1'b1;
          push   = 1'b1;
        end
        default: nxt_phase = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      addr     <= '0;
      oe_q     <= 1'b0;
      ack_pend <= 1'b0;
      rd_go    <= 1'b0;
    end else if (start_det) begin
      phase    <= PH_DEV;
      bit_cnt  <= '0;
      oe_q     <= 1'b0;
      ack_pend <= 1'b0;
      rd_go    <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      oe_q     <= 1'b0;
      ack_pend <= 1'b0;
    end else begin
      if (scl_rise && (phase != PH_IDLE) && (bit_cnt != 4'd9)) begin
        bit_cnt <= bit_cnt + 4'd1;
        shreg   <= byte_in;
      end
      if (byte_done) begin
        phase    <= nxt_phase;
        ack_pend <= ack_go;
        if (ack_go && (nxt_phase == PH_RDAT)) rd_go <= 1'b1;
      end
      if (base_set) addr <= byte_in;
      if (push)     addr <= page_step(addr);
      if (mack_rise) rd_go <= ~sda_lvl;
      if (scl_fall && (phase != PH_IDLE)) begin
        if (bit_cnt == 4'd8) begin
          oe_q <= ack_pend;
        end else if (bit_cnt == 4'd9) begin
          bit_cnt  <= '0;
          ack_pend <= 1'b0;
          if ((phase == PH_RDAT) && rd_go) begin
            tx   <= rd_data;
            oe_q <= ~rd_data[DW-1];
            addr <= seq_step(addr);
          end else begin
            oe_q <= 1'b0;
            if (phase == PH_RDAT) phase <= PH_IDLE;
          end
        end else if ((phase == PH_RDAT) && (bit_cnt != 4'd0)) begin
          oe_q <= ~tx[3'd7 - bit_cnt[2:0]];
        end
      end
    end
  end

  assign sda_oe = oe_q;

  eep_page_buf #(.CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(start_det), .push(push),
    .push_slot(addr[PW-1:0]), .push_data(byte_in),
    .base_set(base_set), .base_page(byte_in[AW-1:PW]),
    .commit_req(commit_req), .prog_cycles(prog_cycles),
    .busy(busy), .any_valid(any_valid), .wr_fire(wr_fire),
    .wr_page(wr_page), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  eep_array u_mem (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_page(wr_page),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(addr), .rd_data(rd_data)
  );

  assert_start_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bit_cnt == 4'd0) && (phase == PH_DEV) && !oe_q)
    else $error("start did not realign the bit position");
  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && !start_det && !stop_det) |=> $stable(oe_q))
    else $error("SDA drive changed while SCL high");
  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack_go)
    else $error("acknowledge decided during programming cycle");
  assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fall && (phase == PH_RDAT) && !rd_go) |=> !oe_q && (phase == PH_IDLE))
    else $error("SDA not released after master NACK");
endmodule

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int Q = 8;
  localparam logic [15:0] PROG = 16'd400;
  localparam logic [7:0] DW_B = 8'hA0;
  localparam logic [7:0] DR_B = 8'hA1;
  // {word address, data}
  localparam logic [15:0] VEC [0:5] = '{16'h003C, 16'h01C5, 16'h7F81,
                                         16'hA55A, 16'hFEE7, 16'hFF18};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int total = 0;
  int fails = 0;
  int unstable = 0;
  bit done = 0;
  logic ak;
  logic [7:0] rb;
  logic [7:0] exp_pg [16];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eeprom_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .prog_cycles(PROG), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    acked = (sda_line == 1'b0);
    q(); scl_m = 1'b0; q();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic v1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      v1 = sda_line; d[i] = v1;
      q();
      if (sda_line !== v1) unstable++;
      scl_m = 1'b0; q();
    end
    put_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  // set word address with a write, then repeated start into read
  task automatic rd_open(input logic [7:0] a, input string req);
    bus_start();
    send_byte(DW_B, ak); chk({req, " dev W ack"}, ak, 1);
    send_byte(a, ak);    chk({req, " addr ack"}, ak, 1);
    bus_start();
    send_byte(DR_B, ak); chk({req, " dev R ack"}, ak, 1);
  endtask

  task automatic wr_one(input logic [7:0] a, input logic [7:0] d);
    bus_start();
    send_byte(DW_B, ak); chk("R2 dev ack", ak, 1);
    send_byte(a, ak);    chk("R4 addr ack", ak, 1);
    send_byte(d, ak);    chk("R4 data ack", ak, 1);
    bus_stop();
  endtask

  task automatic probe(output logic acked);
    bus_start(); send_byte(DW_B, acked); bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sda released after reset", sda_oe, 0);

    // R11 erased content, R10 address-only write then read
    rd_open(8'h00, "R10");
    get_byte(1'b0, rb);
    chk("R11 erased byte", rb, 8'hFF);
    chk("R9 released after NACK", sda_oe, 0);
    bus_stop();
    probe(ak);
    chk("R10 no programming cycle without data", ak, 1);

    // vector table: write, busy probe, read back
    for (int v = 0; v < 6; v++) begin
      wr_one(VEC[v][15:8], VEC[v][7:0]);
      probe(ak);
      chk("R6 no ack while programming", ak, 0);
      repeat (int'(PROG) + 40) @(negedge clk);
      rd_open(VEC[v][15:8], "R5");
      get_byte(1'b0, rb);
      bus_stop();
      chk("R5 committed byte", rb, VEC[v][7:0]);
    end

    // R7: 18 bytes into page 0x30 starting at slot 4
    bus_start();
    send_byte(DW_B, ak); chk("R4 dev ack", ak, 1);
    send_byte(8'h34, ak); chk("R4 addr ack", ak, 1);
    for (int i = 0; i < 18; i++) begin
      send_byte(8'h80 + 8'(i), ak);
      chk("R7 page data ack", ak, 1);
      exp_pg[(4 + i) % 16] = 8'h80 + 8'(i);
    end
    bus_stop();
    repeat (int'(PROG) + 40) @(negedge clk);
    rd_open(8'h30, "R7");
    for (int j = 0; j < 16; j++) begin
      get_byte(j != 15, rb);
      chk("R7 page slot content", rb, exp_pg[j]);
    end
    bus_stop();
    rd_open(8'h40, "R7");
    get_byte(1'b0, rb);
    bus_stop();
    chk("R7 next page untouched", rb, 8'hFF);
    rd_open(8'h2F, "R7");
    get_byte(1'b0, rb);
    bus_stop();
    chk("R7 previous page untouched", rb, 8'hFF);

    // R8: sequential read across the top of the array
    unstable = 0;
    rd_open(8'hFE, "R8");
    get_byte(1'b1, rb); chk("R8 read FE", rb, 8'hE7);
    get_byte(1'b1, rb); chk("R8 read FF", rb, 8'h18);
    get_byte(1'b0, rb); chk("R8 wrap to 00", rb, 8'h3C);
    chk("R3 read bits stable while SCL high", unstable, 0);
    repeat (3 * Q) @(negedge clk);
    chk("R9 SDA stays released after NACK", sda_oe, 0);
    bus_stop();

    // R2: other device id is ignored, word address kept at 0x01
    bus_start();
    send_byte(8'hA2, ak); chk("R2 foreign id not acked", ak, 0);
    send_byte(8'h7F, ak); chk("R2 following byte ignored", ak, 0);
    bus_stop();
    bus_start();
    send_byte(DR_B, ak); chk("R2 current read ack", ak, 1);
    get_byte(1'b0, rb);
    bus_stop();
    chk("R2 R10 address unchanged by ignored byte", rb, 8'hC5);

    // R1: start in the middle of a byte realigns
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    rd_open(8'h7F, "R1");
    get_byte(1'b0, rb);
    bus_stop();
    chk("R1 read after mid-byte start", rb, 8'h81);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule